// File: doc/BRIEF.md
# Non-volatile shadow SRAM sequence controller

This block models a small static RAM with a non-volatile shadow copy. Normal chip-enabled cycles read or write the RAM. A controller watches the read traffic for a fixed six-address unlock pattern. When the pattern completes, the block copies the RAM into the shadow (store) or copies the shadow back into the RAM (restore), depending on the last address of the pattern.

Once a copy has started it runs for a fixed number of clock cycles and ignores every input. The one exception is the supply-good flag: dropping it cancels a store, and the shadow keeps its earlier contents. A restore cannot be cancelled. When supply-good first comes up, a restore runs on its own before any access is allowed.

The data words are indexed by the low `IDX_W` address bits. The unlock pattern is compared against the full 13-bit address. All durations are counted in clock cycles.

Top module: `nvsram_seq`

## Requirements
- R1: From reset, and while `pwr_ok` is low, the block is powered off. In that state `busy` is 1 and `rdata_oe` is 0, whatever the access inputs are.
- R2: When `pwr_ok` is high in the powered-off state, a restore starts on the next clock. `busy` stays 1 for exactly `RECALL_CYCLES` cycles, and the RAM then holds the shadow contents. At reset the shadow and the RAM are both all zero.
- R3: An access is a clock edge at which `ce_n` is low and either `ce_n` was high at the previous edge or `addr` differs from its value at the previous edge. An access with `we_n` = 0 writes `wdata` to the word `addr[IDX_W-1:0]`. `rdata_oe` is 1 only when the block is idle, `ce_n` = 0, `we_n` = 1 and `oe_n` = 0. `rdata` shows the addressed word.
- R4: Six consecutive read accesses at 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F start a store. The same pattern ending in 0x0F0E starts a restore. `busy` rises on the clock that takes the sixth access.
- R5: A write access, or an access at an address other than the one expected next, resets the matcher. An out-of-order access at 0x0000 counts as the first step of a new pattern.
- R6: The first five accesses of the pattern are normal reads that drive data. On the sixth access `rdata_oe` stays 0.
- R7: `oe_n` has no effect on recognising the pattern.
- R8: While `busy` is 1, reads leave `rdata_oe` at 0, writes are dropped and accesses do not advance the matcher.
- R9: A store keeps `busy` at 1 for `STORE_CYCLES` cycles and then makes the shadow equal to the RAM as it was when the store started. A restore started by the pattern lasts `RECALL_CYCLES` cycles and then copies the shadow into the RAM.
- R10: If `pwr_ok` is low during a store, the store is cancelled, the shadow is left unchanged and the block goes to the powered-off state. A restore runs its full length whatever `pwr_ok` does.
- R11: Data words alias modulo 2^`IDX_W` in the address. The unlock pattern compares all 13 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low; gates the data bus only |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Write data |
| pwr_ok | input | 1 | Supply-good flag |
| rdata | output | DATA_W | Read data for the addressed word |
| rdata_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| busy | output | 1 | Powered off, storing or restoring |

## Verification
Two things can land on the same clock. The supply-good flag can fall while a store is counting, and ordinary accesses can arrive while a copy is running. The bench drops `pwr_ok` part-way through a store, holds it low, then raises it again. It then checks that the automatic restore brings back the older shadow image and not the newer RAM data. It also pulls `pwr_ok` low and then high again within a restore, and it issues a write and a read while a store is running. These cases are judged by the exact number of busy cycles, by reading back the data afterwards, and by `rdata_oe` staying low throughout the busy period.

// File: rtl/nvsram_seq.sv
module nvsram_seq #(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int IDX_W         = 4,
  parameter int STORE_CYCLES  = 2000,
  parameter int RECALL_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pwr_ok,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  output logic              busy
);
  localparam int WORDS = 1 << IDX_W;
  localparam int MAXC  = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  localparam logic [1:0] S_OFF = 2'd0, S_IDLE = 2'd1, S_STORE = 2'd2, S_RECALL = 2'd3;

  localparam logic [ADDR_W-1:0] K_FIRST  = ADDR_W'(13'h0000);
  localparam logic [ADDR_W-1:0] K_STORE  = ADDR_W'(13'h0F0F);
  localparam logic [ADDR_W-1:0] K_RECALL = ADDR_W'(13'h0F0E);

  function automatic logic [ADDR_W-1:0] key(input logic [2:0] s);
    case (s)
      3'd0:    key = K_FIRST;
      3'd1:    key = ADDR_W'(13'h1555);
      3'd2:    key = ADDR_W'(13'h0AAA);
      3'd3:    key = ADDR_W'(13'h1FFF);
      3'd4:    key = ADDR_W'(13'h10F0);
      default: key = K_STORE;
    endcase
  endfunction

  logic [1:0]        st;
  logic [2:0]        step;
  logic [CNT_W-1:0]  cnt;
  logic              prev_ce_n;
  logic [ADDR_W-1:0] prev_addr;
  logic [DATA_W-1:0] sram   [WORDS];
  logic [DATA_W-1:0] shadow [WORDS];
  logic [DATA_W-1:0] stage  [WORDS];

  wire [IDX_W-1:0] idx     = addr[IDX_W-1:0];
  wire             access  = !ce_n && (prev_ce_n || addr != prev_addr);
  wire             idle    = st == S_IDLE;
  wire             last_st = step == 3'd5 && addr == K_STORE;
  wire             last_rc = step == 3'd5 && addr == K_RECALL;

  assign busy     = !idle;
  assign rdata    = sram[idx];
  assign rdata_oe = idle && !ce_n && we_n && !oe_n && !(last_st || last_rc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_OFF;
      step      <= '0;
      cnt       <= '0;
      prev_ce_n <= 1'b1;
      prev_addr <= '0;
      for (int i = 0; i < WORDS; i++) begin
        sram[i]   <= '0;
        shadow[i] <= '0;
        stage[i]  <= '0;
      end
    end else begin
      prev_ce_n <= ce_n;
      prev_addr <= addr;
      case (st)
        S_OFF: if (pwr_ok) begin
          st  <= S_RECALL;
          cnt <= CNT_W'(RECALL_CYCLES - 1);
        end
        S_IDLE: begin
          if (!pwr_ok) begin
            st   <= S_OFF;
            step <= '0;
          end else if (access) begin
            if (!we_n) begin
              sram[idx] <= wdata;
              step      <= '0;
            end else if (last_st) begin
              step <= '0;
              st   <= S_STORE;
              cnt  <= CNT_W'(STORE_CYCLES - 1);
              for (int i = 0; i < WORDS; i++) stage[i] <= sram[i];
            end else if (last_rc) begin
              step <= '0;
              st   <= S_RECALL;
              cnt  <= CNT_W'(RECALL_CYCLES - 1);
            end else if (step != 3'd5 && addr == key(step)) begin
              step <= 3'(step + 3'd1);
            end else begin
              step <= (addr == K_FIRST) ? 3'd1 : 3'd0;
            end
          end
        end
        S_STORE: begin
          if (!pwr_ok) begin
            st <= S_OFF;
          end else if (cnt == '0) begin
            for (int i = 0; i < WORDS; i++) shadow[i] <= stage[i];
            st <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            for (int i = 0; i < WORDS; i++) sram[i] <= shadow[i];
            st <= pwr_ok ? S_IDLE : S_OFF;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nvsram_seq_chk.sv
module nvsram_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic       pwr_ok,
  input logic       rdata_oe,
  input logic       busy,
  input logic [1:0] st,
  input logic [2:0] step,
  input logic       cnt_zero
);
  a_r8_busy_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rdata_oe);

  a_r3_drive_cond: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!ce_n && we_n && !oe_n));

  a_r10_store_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !pwr_ok) |=> st == 2'd0);

  a_r10_recall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !cnt_zero) |=> st == 2'd3);

  a_r2_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && pwr_ok) |=> st == 2'd3);

  a_r5_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 3'd5);

  a_r8_matcher_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 || st == 2'd3) |-> step == 3'd0);
endmodule

bind nvsram_seq nvsram_seq_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .pwr_ok   (pwr_ok),
  .rdata_oe (rdata_oe),
  .busy     (busy),
  .st       (st),
  .step     (step),
  .cnt_zero (cnt == '0)
);

// File: tb/nvsram_seq_tb.sv
`timescale 1ns/1ps
module nvsram_seq_tb_top;
  localparam int SC = 2000;
  localparam int RC = 20;

  logic        clk = 0;
  logic        rst_n, ce_n, we_n, oe_n, pwr_ok;
  logic [12:0] addr;
  logic [7:0]  wdata, rdata;
  logic        rdata_oe, busy;
  int          checks = 0, fails = 0;

  always #5 clk = ~clk;

  nvsram_seq #(.ADDR_W(13), .DATA_W(8), .IDX_W(4), .STORE_CYCLES(SC), .RECALL_CYCLES(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .wdata(wdata), .pwr_ok(pwr_ok), .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one access: inputs set just after a negedge, released after the edge
  task automatic acc(input logic [12:0] a, input logic w, input logic [7:0] d, input logic oe,
                     output logic seen_oe, output logic [7:0] seen_d);
    ce_n = 0; addr = a; we_n = w; wdata = d; oe_n = oe;
    #1; seen_oe = rdata_oe; seen_d = rdata;
    @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    logic o; logic [7:0] r;
    acc(a, 0, d, 0, o, r);
  endtask

  task automatic rd_chk(input string req, input logic [12:0] a, input logic [7:0] e);
    logic o; logic [7:0] r;
    acc(a, 1, 0, 0, o, r);
    chk({req, " drive"}, o, 1);
    chk({req, " data"}, r, e);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  // full unlock pattern; oe_n high on step 1 exercises R7
  task automatic unlock(input logic [12:0] last, input string req);
    logic [12:0] keys [6];
    logic o; logic [7:0] r;
    keys = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, last};
    for (int i = 0; i < 6; i++) begin
      acc(keys[i], 1, 0, (i == 1), o, r);
      if (i < 5) chk({req, " R6/R7 pattern read drive"}, o, (i != 1));
      else       chk({req, " R6 sixth access hi-z"}, o, 0);
    end
    chk({req, " R4 busy after pattern"}, busy, 1);
  endtask

  task automatic t_reset();
    rst_n = 0; pwr_ok = 0; ce_n = 1; we_n = 1; oe_n = 0; addr = 0; wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    ce_n = 0;
    @(negedge clk);
    #1;
    chk("R1 busy after reset", busy, 1);
    chk("R1 no drive while off", rdata_oe, 0);
    ce_n = 1;
    @(negedge clk);
    pwr_ok = 1;
    @(negedge clk);
    begin
      int n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R2 power-up restore length", n, RC);
    end
    rd_chk("R2 zero shadow restored", 13'h0003, 8'h00);
  endtask

  task automatic t_rw();
    logic o; logic [7:0] r;
    for (int i = 0; i < 4; i++) wr(13'(i), 8'(8'hA0 + i));
    for (int i = 0; i < 4; i++) rd_chk("R3 read back", 13'(i), 8'(8'hA0 + i));
    acc(13'h0002, 1, 0, 1, o, r);
    chk("R3 oe_n high no drive", o, 0);
    wr(13'h0017, 8'h3C);
    rd_chk("R11 alias word", 13'h0007, 8'h3C);
  endtask

  task automatic t_store_recall();
    int n;
    unlock(13'h0F0F, "store");
    n = 1;  // first busy cycle elapsed inside the last access
    while (busy) begin
      if (n == 5) begin ce_n = 0; we_n = 0; addr = 13'h0001; wdata = 8'hEE; end
      if (n == 6) begin ce_n = 1; we_n = 1; end
      if (n == 8) begin ce_n = 0; addr = 13'h0002; oe_n = 0; #1; chk("R8 no drive while busy", rdata_oe, 0); end
      if (n == 9) ce_n = 1;
      n++;
      @(negedge clk);
    end
    chk("R9 store length", n, SC);
    rd_chk("R8 write during busy dropped", 13'h0001, 8'hA1);
    for (int i = 0; i < 4; i++) wr(13'(i), 8'(8'h50 + i));
    rd_chk("R3 overwrite", 13'h0001, 8'h51);
    unlock(13'h0F0E, "recall");
    n = 1;
    while (busy) begin n++; @(negedge clk); end
    chk("R9 restore length", n, RC);
    for (int i = 0; i < 4; i++) rd_chk("R4 restore data", 13'(i), 8'(8'hA0 + i));
  endtask

  task automatic t_broken();
    logic o; logic [7:0] r;
    logic [12:0] bad [6];
    wr(13'h0002, 8'h77);
    bad = '{13'h0000, 13'h1555, 13'h0AAB, 13'h1FFF, 13'h10F0, 13'h0F0F};
    for (int i = 0; i < 6; i++) acc(bad[i], 1, 0, 0, o, r);
    chk("R5 wrong address sixth drives", o, 1);
    chk("R5 wrong address no start", busy, 0);
    acc(13'h0000, 1, 0, 0, o, r);
    acc(13'h1555, 1, 0, 0, o, r);
    acc(13'h0AAA, 0, 8'h11, 0, o, r);
    acc(13'h1FFF, 1, 0, 0, o, r);
    acc(13'h10F0, 1, 0, 0, o, r);
    acc(13'h0F0F, 1, 0, 0, o, r);
    chk("R5 write in pattern no start", busy, 0);
    acc(13'h0000, 1, 0, 0, o, r);
    acc(13'h1555, 1, 0, 0, o, r);
    unlock(13'h0F0E, "R5 restart");
    wait_idle();
    rd_chk("R5 restart restore", 13'h0002, 8'hA2);
  endtask

  task automatic t_abort();
    int n;
    for (int i = 0; i < 4; i++) wr(13'(i), 8'(8'hC0 + i));
    unlock(13'h0F0F, "abort");
    n = 1;
    while (n < 10) begin n++; @(negedge clk); end
    pwr_ok = 0;
    repeat (30) @(negedge clk);
    chk("R10 busy after abort", busy, 1);
    pwr_ok = 1;
    @(negedge clk);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R10 restore after abort", n, RC);
    for (int i = 0; i < 4; i++) rd_chk("R10 shadow kept", 13'(i), 8'(8'hA0 + i));
    unlock(13'h0F0E, "dip");
    n = 1;
    while (busy) begin
      if (n == 3) pwr_ok = 0;
      if (n == 6) pwr_ok = 1;
      n++;
      @(negedge clk);
    end
    chk("R10 restore not cancelled", n, RC);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rw();
    t_store_recall();
    t_broken();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule